// File: doc/BRIEF.md
# EEPROM Write-Completion Polling Read Responder

This block sits on the read path of an EEPROM beside the engine that programs pages into the array. While an internal programming cycle runs, the array cannot be read. The block answers reads with a status word built from the most recently loaded byte, with bit 7 inverted. A host detects the end of programming by reading until bit 7 matches the value it wrote. No fixed delay is needed, and the host may start polling at any time during the cycle.

The block records the address and data of every accepted byte load. During programming a qualifying read returns the recorded byte with bit 7 inverted and bits 6 to 0 unchanged. When the busy flag is low, array data is passed through. A read qualifies when chip select and output enable are low and write enable is high. The registered output carries read data and a drive indication for the external tristate buffer.

By default every read address returns the status word during programming. With the `MATCH_ONLY` parameter set, only the recorded address does, and other addresses see array data. All outputs follow the sampled inputs by one clock.

Top module: `poll_status_resp`

## Requirements
- R1: After reset, `rd_drive` is 0 and `rd_data` is 0. The recorded address and data are 0, so a match-only busy read at address 0 before any load returns 8'h80.
- R2: When `cs_n`=0, `oe_n`=0 and `we_n`=1 are sampled on a clock edge, `rd_drive` is 1 after that edge.
- R3: When any other strobe combination is sampled, `rd_drive` is 0 and `rd_data` is 0 after that edge. This includes `cs_n`=`oe_n`=1, output enable high with chip select low, and write enable low.
- R4: For a read sampled while `busy`=1 that returns the status word, bit 7 of `rd_data` is the inverse of bit 7 of the recorded data. This already holds for a read in the first cycle after the load.
- R5: For that status read, bits 6 to 0 of `rd_data` equal bits 6 to 0 of the recorded data.
- R6: With `MATCH_ONLY`=0, every read address returns the status word while `busy`=1.
- R7: A read sampled while `busy`=0 returns `arr_data` as sampled in that cycle. This includes the first read after `busy` falls.
- R8: A cycle with `ld_stb`=1 records `ld_addr` and `ld_data`, and a later load replaces them. A read sampled in the same cycle as a load still sees the previous record.
- R9: With `MATCH_ONLY`=1 and `busy`=1, a read at the recorded address returns the status word and a read at any other address returns `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | ADDR_W | Read address |
| busy | input | 1 | Internal programming cycle in progress |
| ld_stb | input | 1 | Accepted byte load, one cycle per byte |
| ld_addr | input | ADDR_W | Address of the loaded byte |
| ld_data | input | DATA_W | Value of the loaded byte |
| arr_data | input | DATA_W | Array contents at `rd_addr` |
| rd_data | output | DATA_W | Registered read data |
| rd_drive | output | 1 | Registered drive enable for the tristate data bus |

## Verification
The assertions check on every cycle that:
- a read strobe produces a drive;
- both strobes high release the bus;
- a busy status read has an inverted bit 7 and untouched low bits;
- a read while idle carries array data;
- a load is recorded.

Only the bench scenarios can show some behaviours:
- the difference between the two address modes;
- that the newest load replaces an older one;
- that a read in the same cycle as a load uses the older record;
- the hand-over to true data as soon as busy falls.

// File: rtl/poll_status_resp.sv
module poll_status_resp #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int FLAG_BIT   = 7,
  parameter bit MATCH_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;
  localparam logic [DATA_W-1:0] LOW_MASK  = FLAG_MASK - DATA_W'(1);

  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  wire rd_req   = !cs_n && !oe_n && we_n;
  wire addr_hit = !MATCH_ONLY || (rd_addr == last_addr);
  wire [DATA_W-1:0] poll_word = last_data ^ FLAG_MASK;
  wire [DATA_W-1:0] next_word = !rd_req             ? '0 :
                                (busy && addr_hit)  ? poll_word : arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_drive  <= 1'b0;
      rd_data   <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      rd_drive <= rd_req;
      rd_data  <= next_word;
      if (ld_stb) begin
        last_addr <= ld_addr;
        last_data <= ld_data;
      end
    end
  end

  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && we_n) |=> rd_drive); // R2

  AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && oe_n) |=> (!rd_drive && rd_data == '0)); // R3

  AST_POLL_FLAG_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && addr_hit && !ld_stb) |=>
      (rd_data[FLAG_BIT] != last_data[FLAG_BIT])); // R4

  AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && addr_hit && !ld_stb) |=>
      ((rd_data & LOW_MASK) == (last_data & LOW_MASK))); // R5

  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> (rd_data == $past(arr_data))); // R7

  AST_LOAD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (last_data == $past(ld_data) && last_addr == $past(ld_addr))); // R8

endmodule

// File: tb/poll_status_resp_tb_top.sv
`timescale 1ns/1ps
module poll_status_resp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] rd_addr = '0;
  logic        busy = 1'b0, ld_stb = 1'b0;
  logic [16:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  arr_data;
  logic [7:0]  rd_data_i, rd_data_m;
  logic        rd_drive_i, rd_drive_m;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign arr_data = rd_addr[7:0] ^ 8'hA5;

  poll_status_resp dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .busy(busy), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_data(ld_data), .arr_data(arr_data), .rd_data(rd_data_i), .rd_drive(rd_drive_i));

  poll_status_resp #(.MATCH_ONLY(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .busy(busy), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_data(ld_data), .arr_data(arr_data), .rd_data(rd_data_m), .rd_drive(rd_drive_m));

  // behavioural reference
  logic [16:0] m_addr;
  logic [7:0]  m_data;
  logic        exp_drive;
  logic [7:0]  exp_i, exp_m;
  initial begin m_addr = '0; m_data = '0; exp_drive = 0; exp_i = 0; exp_m = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = '0; m_data = '0; exp_drive = 0; exp_i = 0; exp_m = 0;
    end else begin
      bit req;
      req = (cs_n == 0) && (oe_n == 0) && (we_n == 1);
      exp_drive = req;
      if (!req) begin
        exp_i = 0; exp_m = 0;
      end else begin
        exp_i = busy ? {~m_data[7], m_data[6:0]} : arr_data;
        exp_m = (busy && rd_addr == m_addr) ? {~m_data[7], m_data[6:0]} : arr_data;
      end
      if (ld_stb) begin m_addr = ld_addr; m_data = ld_data; end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    check(tag, {7'b0, rd_drive_i}, {7'b0, exp_drive}, "drive (default)");
    check(tag, {7'b0, rd_drive_m}, {7'b0, exp_drive}, "drive (match)");
    check(tag, rd_data_i, exp_i, "data (default)");
    check(tag, rd_data_m, exp_m, "data (match)");
  endtask

  task automatic set_rd(input logic c, input logic o, input logic w, input logic [16:0] a);
    cs_n = c; oe_n = o; we_n = w; rd_addr = a;
  endtask

  task automatic load(input logic [16:0] a, input logic [7:0] d);
    ld_stb = 1; ld_addr = a; ld_data = d;
  endtask

  bit done = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    // idle read, not busy
    set_rd(0, 0, 1, 17'h00010); step("R2_R7");
    set_rd(1, 1, 1, 17'h00010); step("R3");
    set_rd(0, 1, 1, 17'h00010); step("R3");
    set_rd(0, 0, 0, 17'h00010); step("R3");
    // match-only busy read before any load: record is zero
    busy = 1; set_rd(0, 0, 1, 17'h0); step("R1_R9");
    busy = 0; set_rd(1, 1, 1, 17'h0);
    // load and start programming
    load(17'h01234, 8'h3C); step("R8");
    ld_stb = 0; busy = 1;
    set_rd(0, 0, 1, 17'h01234); step("R4_R5");
    set_rd(0, 0, 1, 17'h00077); step("R6_R9");
    set_rd(1, 1, 1, 17'h00077); step("R3");
    // read in the same cycle as a new load sees the old record
    set_rd(0, 0, 1, 17'h01234); load(17'h01235, 8'hC5); step("R8");
    ld_stb = 0;
    set_rd(0, 0, 1, 17'h01235); step("R8_R4");
    set_rd(0, 0, 1, 17'h01234); step("R9");
    set_rd(0, 0, 1, 17'h1FFFF); step("R6");
    // programming ends
    busy = 0; set_rd(0, 0, 1, 17'h01235); step("R7");
    set_rd(0, 0, 1, 17'h00042); step("R7");
    // sweep of page loads with polling
    for (int k = 0; k < 8; k++) begin
      load(17'h02000 + 17'(k), 8'(k * 37 + 3)); busy = 1; set_rd(1, 1, 1, '0); step("R8");
      ld_stb = 0; set_rd(0, 0, 1, 17'h02000 + 17'(k)); step("R4_R5");
      set_rd(0, 0, 1, 17'h00100 + 17'(k)); step("R6_R9");
    end
    busy = 0; set_rd(0, 0, 1, 17'h02007); step("R7");
    set_rd(1, 1, 1, '0); step("R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule